// File: doc/BRIEF.md
# Barrel Shifter with Normalization

This unit is the shift stage of a 16-bit fixed-point datapath. Each issued operation takes a 16-bit operand and places it in the upper or lower half of a 32-bit field. It then shifts that field by a signed amount, or by an amount it derives from the operand itself. The outcome lands in a 32-bit result register, so any neighbouring unit can read it on the next cycle.

The unit offers logical and arithmetic shifts, exponent derivation, normalization and denormalization. Exponent derivation counts the redundant sign bits of the operand. Normalization shifts the operand left by that count, and denormalization shifts it right by a supplied amount. An OR mode merges the new shifted value into the value already held. This lets two 16-bit halves be assembled into one 32-bit word, which supports multiprecision work.

Top module: `shifter_unit`

## Requirements
- R1: While rst_ni is low, result_o is 0 and exp_o is 0.
- R2: Op code 0 (logical shift): a positive amt_i (8-bit two's complement) shifts the placed value left and a negative one shifts it right, both filling with zeros.
- R3: Op code 1 (arithmetic shift): left shifts match op 0; right shifts fill vacated bits with bit 31 of the placed value.
- R4: With hi_sel_i=1 the operand occupies bits 31:16 and bits 15:0 are zero. With hi_sel_i=0 it occupies bits 15:0, and bits 31:16 are zero for op 0 and copies of operand bit 15 for ops 1, 2 and 3.
- R5: A shift magnitude of 32 or more gives a full shift. To the left the result is 0. To the right it is 0 for op 0 and 32 copies of the placed value's bit 31 for ops 1 and 3.
- R6: Op code 4 (derive exponent) writes to exp_o the count of operand bits below bit 15 that equal bit 15 contiguously from bit 14 down, which is 15 for 0x0000 and 0xFFFF. result_o is left unchanged.
- R7: Op code 2 (normalize) arithmetically shifts the placed value left by the operand's derived exponent. It also writes that exponent to exp_o.
- R8: Op code 3 (denormalize) arithmetically shifts the placed value right by amt_i. A negative amt_i shifts it left.
- R9: With or_i=1, a result-writing op stores the bitwise OR of the previous result_o and the new shifted value.
- R10: Outputs change only on the rising clock edge at which valid_i is 1. With valid_i=0, or with op codes 5 to 7, both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Operation code (0 lsh, 1 ash, 2 norm, 3 denorm, 4 exp) |
| amt_i | input | 8 | Signed shift amount, positive is left |
| hi_sel_i | input | 1 | Place operand in upper (1) or lower (0) half |
| or_i | input | 1 | OR the shifted value into the held result |
| operand_i | input | 16 | Operand |
| result_o | output | 32 | Registered 32-bit result |
| exp_o | output | 4 | Registered derived exponent |

## Verification
The hardest condition to reach is the shift-amount boundary at ±32 combined with each fill rule. It is rare under uniform random amounts, and the bench handles it in two ways. It draws most amounts from a narrow window around ±40, and it adds directed vectors at exactly 31, 32, -32 and -128 for the denormalize negation case. Operands with long sign runs are equally rare from uniform draws. The stimulus therefore builds them by arithmetically shifting a random word right by a random count, and adds the two all-equal words as directed cases.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXPD   = 3'd4
  } shf_op_e;

  typedef struct packed {
    logic left;
    logic arith;
    logic sat;
    logic wr_res;
    logic wr_exp;
  } shf_ctrl_t;
endpackage

// File: rtl/shf_sign_detect.sv
module shf_sign_detect #(
  parameter int DATA_W = 16,
  parameter int EXP_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] x_i,
  output logic [EXP_W-1:0]  cnt_o
);
  logic [DATA_W-2:0] run;

  assign run[DATA_W-2] = x_i[DATA_W-2] ~^ x_i[DATA_W-1];
  for (genvar i = DATA_W - 3; i >= 0; i--) begin : g_run
    assign run[i] = run[i+1] & (x_i[i] ~^ x_i[DATA_W-1]);
  end

  assign cnt_o = EXP_W'($countones(run));

  // the first bit past the counted run must differ from the sign
  always_comb begin
    if (int'(cnt_o) < DATA_W - 1) begin
      AST_RUN_END: assert (x_i[DATA_W-2-int'(cnt_o)] != x_i[DATA_W-1]); // R6
    end
  end
endmodule

// File: rtl/shf_amt_decode.sv
module shf_amt_decode
  import shifter_pkg::*;
#(
  parameter int AMT_W = 8,
  parameter int EXP_W = 4,
  parameter int RES_W = 32,
  parameter int SH_W  = $clog2(RES_W)
) (
  input  shf_op_e          op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [EXP_W-1:0] exp_i,
  output shf_ctrl_t        ctrl_o,
  output logic [SH_W-1:0]  sh_o
);
  localparam int EFF_W = AMT_W + 1;

  logic signed [EFF_W-1:0] eff;
  logic        [EFF_W-1:0] mag;
  shf_ctrl_t               c;

  always_comb begin
    c   = '0;
    eff = '0;
    case (op_i)
      OP_LSH: begin
        eff      = EFF_W'($signed(amt_i));
        c.wr_res = 1'b1;
      end
      OP_ASH: begin
        eff      = EFF_W'($signed(amt_i));
        c.arith  = 1'b1;
        c.wr_res = 1'b1;
      end
      OP_NORM: begin
        eff      = $signed(EFF_W'(exp_i));
        c.arith  = 1'b1;
        c.wr_res = 1'b1;
        c.wr_exp = 1'b1;
      end
      OP_DENORM: begin
        eff      = -EFF_W'($signed(amt_i));
        c.arith  = 1'b1;
        c.wr_res = 1'b1;
      end
      OP_EXPD: c.wr_exp = 1'b1;
      default: ;
    endcase
    mag    = eff[EFF_W-1] ? EFF_W'(-eff) : EFF_W'(eff);
    c.left = ~eff[EFF_W-1];
    c.sat  = mag >= EFF_W'(RES_W);
  end

  assign ctrl_o = c;
  assign sh_o   = mag[SH_W-1:0];

  always_comb begin
    if (op_i == OP_EXPD) begin
      AST_EXPD_NO_WRITE: assert (!c.wr_res); // R6
    end
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int RES_W = 32,
  parameter int SH_W  = $clog2(RES_W)
) (
  input  logic [RES_W-1:0] data_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             left_i,
  input  logic             arith_i,
  input  logic             sat_i,
  output logic [RES_W-1:0] data_o
);
  logic [RES_W-1:0] lst [SH_W+1];
  logic [RES_W-1:0] rst [SH_W+1];
  logic             fill;

  assign lst[0] = data_i;
  assign rst[0] = data_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign lst[k+1] = sh_i[k] ? (lst[k] << (2**k)) : lst[k];
    assign rst[k+1] = !sh_i[k] ? rst[k] :
                      arith_i  ? RES_W'($signed(rst[k]) >>> (2**k)) :
                                 (rst[k] >> (2**k));
  end

  assign fill = arith_i & data_i[RES_W-1];

  always_comb begin
    if (sat_i) data_o = left_i ? '0 : {RES_W{fill}};
    else       data_o = left_i ? lst[SH_W] : rst[SH_W];
  end
endmodule

// File: rtl/shifter_unit.sv
module shifter_unit
  import shifter_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int AMT_W  = 8,
  localparam int RES_W  = 2 * DATA_W,
  localparam int EXP_W  = $clog2(DATA_W),
  localparam int SH_W   = $clog2(RES_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              hi_sel_i,
  input  logic              or_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [RES_W-1:0]  result_o,
  output logic [EXP_W-1:0]  exp_o
);
  shf_op_e          op;
  shf_ctrl_t        ctrl;
  logic [EXP_W-1:0] exp_d;
  logic [SH_W-1:0]  sh;
  logic [RES_W-1:0] placed;
  logic [RES_W-1:0] shifted;
  logic [RES_W-1:0] res_q;
  logic [EXP_W-1:0] exp_q;

  assign op = shf_op_e'(op_i);

  shf_sign_detect #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_sign (
    .x_i   (operand_i),
    .cnt_o (exp_d)
  );

  shf_amt_decode #(.AMT_W(AMT_W), .EXP_W(EXP_W), .RES_W(RES_W), .SH_W(SH_W)) u_dec (
    .op_i   (op),
    .amt_i  (amt_i),
    .exp_i  (exp_d),
    .ctrl_o (ctrl),
    .sh_o   (sh)
  );

  // operand placement: high half, or low half zero/sign extended
  always_comb begin
    if (hi_sel_i)        placed = {operand_i, {DATA_W{1'b0}}};
    else if (ctrl.arith) placed = {{DATA_W{operand_i[DATA_W-1]}}, operand_i};
    else                 placed = {{DATA_W{1'b0}}, operand_i};
  end

  shf_barrel #(.RES_W(RES_W), .SH_W(SH_W)) u_bar (
    .data_i  (placed),
    .sh_i    (sh),
    .left_i  (ctrl.left),
    .arith_i (ctrl.arith),
    .sat_i   (ctrl.sat),
    .data_o  (shifted)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      exp_q <= '0;
    end else if (valid_i) begin
      if (ctrl.wr_res) res_q <= or_i ? (res_q | shifted) : shifted;
      if (ctrl.wr_exp) exp_q <= exp_d;
    end
  end

  assign result_o = res_q;
  assign exp_o    = exp_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(exp_o)); // R10

  AST_EXPD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd4 |=> $stable(result_o)); // R6

  AST_OR_SUPERSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && or_i |=> (result_o & $past(result_o)) == $past(result_o)); // R9

  AST_NORM_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd2 && hi_sel_i && !or_i &&
    operand_i != '0 && operand_i != '1
    |=> result_o[RES_W-1] != result_o[RES_W-2]); // R7

  AST_SAT_LEFT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd0 && !or_i && $signed(amt_i) >= 32 |=> result_o == '0); // R5

  AST_SAT_RIGHT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd1 && !or_i && $signed(amt_i) <= -32
    |=> result_o == {RES_W{$past(operand_i[DATA_W-1])}}); // R5
endmodule

// File: tb/shifter_unit_tb.sv
`timescale 1ns/1ps
module shifter_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  amt = '0;
  logic        hi = 1'b0;
  logic        orm = 1'b0;
  logic [15:0] x = '0;
  logic [31:0] result;
  logic [3:0]  expo;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] res_m = '0;
  logic [3:0]  exp_m = '0;

  always #2.5 clk = ~clk;

  shifter_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .amt_i(amt),
    .hi_sel_i(hi), .or_i(orm), .operand_i(x), .result_o(result), .exp_o(expo)
  );

  function automatic int exp_of(logic [15:0] v);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (v[i] != v[15]) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] place(logic h, logic ar, logic [15:0] v);
    if (h) return {v, 16'h0};
    if (ar) return {{16{v[15]}}, v};
    return {16'h0, v};
  endfunction

  function automatic logic [31:0] shv(logic [31:0] p, int n, logic ar);
    int m;
    if (n >= 0) return (n >= 32) ? 32'h0 : (p << n);
    m = -n;
    if (m >= 32) return ar ? {32{p[31]}} : 32'h0;
    if (ar) return 32'($signed(p) >>> m);
    return p >> m;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (result !== res_m || expo !== exp_m) begin
      n_bad++;
      $display("FAIL %s: result=%h exp=%0d expected result=%h exp=%0d",
               tag, result, expo, res_m, exp_m);
    end
  endtask

  task automatic apply(logic v, logic [2:0] o, logic [7:0] a, logic h, logic om,
                       logic [15:0] d, string tag);
    logic [31:0] r;
    logic        wr;
    int          sa;
    @(negedge clk);
    valid = v; op = o; amt = a; hi = h; orm = om; x = d;
    sa = int'($signed(a));
    wr = 1'b0;
    r  = '0;
    if (v) begin
      case (o)
        3'd0: begin r = shv(place(h, 1'b0, d), sa, 1'b0); wr = 1'b1; end
        3'd1: begin r = shv(place(h, 1'b1, d), sa, 1'b1); wr = 1'b1; end
        3'd2: begin r = shv(place(h, 1'b1, d), exp_of(d), 1'b1); wr = 1'b1;
                    exp_m = 4'(exp_of(d)); end
        3'd3: begin r = shv(place(h, 1'b1, d), -sa, 1'b1); wr = 1'b1; end
        3'd4: exp_m = 4'(exp_of(d));
        default: ;
      endcase
      if (wr) res_m = om ? (res_m | r) : r;
    end
    @(posedge clk);
    #1;
    check(tag);
  endtask

  string tags [8] = '{"R2", "R3", "R7", "R8", "R6", "R10", "R10", "R10"};

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: result=%h exp=%0d expected run end", result, expo);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    #1;
    check("R1 in reset");
    repeat (3) @(posedge clk);
    #1;
    check("R1 held in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R6 exponent corners
    apply(1, 3'd4, 8'd0, 0, 0, 16'h0000, "R6 zero");
    apply(1, 3'd4, 8'd0, 0, 0, 16'hFFFF, "R6 ones");
    apply(1, 3'd4, 8'd0, 0, 0, 16'h4000, "R6 0x4000");
    apply(1, 3'd4, 8'd0, 0, 0, 16'h0001, "R6 0x0001");
    apply(1, 3'd4, 8'd0, 0, 0, 16'hC000, "R6 0xC000");
    // R4 placement
    apply(1, 3'd0, 8'd0, 0, 0, 16'h8001, "R4 lo zero ext");
    apply(1, 3'd1, 8'd0, 0, 0, 16'h8001, "R4 lo sign ext");
    apply(1, 3'd0, 8'd0, 1, 0, 16'h8001, "R4 hi");
    apply(1, 3'd4, 8'd0, 0, 0, 16'h8000, "R6 result kept");
    // R2 / R3 shifts
    apply(1, 3'd0, 8'hFC, 0, 0, 16'h00F0, "R2 right zero fill");
    apply(1, 3'd0, 8'd3, 1, 0, 16'hF00F, "R2 left");
    apply(1, 3'd1, 8'hFF, 1, 0, 16'h8000, "R3 right sign fill");
    // R5 saturation
    apply(1, 3'd0, 8'd31, 0, 0, 16'h0001, "R5 left 31");
    apply(1, 3'd0, 8'd32, 0, 0, 16'h0001, "R5 left 32");
    apply(1, 3'd0, 8'hE0, 1, 0, 16'h8000, "R5 logical right 32");
    apply(1, 3'd1, 8'hD8, 1, 0, 16'h8000, "R5 arith right 40");
    apply(1, 3'd3, 8'h80, 1, 0, 16'h7FFF, "R5 denorm -128");
    // R7 normalize
    apply(1, 3'd2, 8'd0, 1, 0, 16'h0001, "R7 0x0001");
    apply(1, 3'd2, 8'd0, 1, 0, 16'hFFFF, "R7 ones");
    apply(1, 3'd2, 8'd0, 0, 0, 16'hFFF0, "R7 lo");
    // R8 denormalize
    apply(1, 3'd3, 8'd3, 1, 0, 16'h8000, "R8 right 3");
    apply(1, 3'd3, 8'hFE, 0, 0, 16'h0003, "R8 negative");
    // R9 merge halves
    apply(1, 3'd0, 8'd0, 1, 0, 16'h1234, "R9 upper");
    apply(1, 3'd0, 8'd0, 0, 1, 16'h5678, "R9 lower merged");
    // R10 hold
    apply(0, 3'd0, 8'd4, 0, 0, 16'hAAAA, "R10 idle");
    apply(1, 3'd5, 8'd4, 0, 0, 16'hAAAA, "R10 code 5");
    apply(1, 3'd7, 8'd1, 1, 1, 16'h5555, "R10 code 7");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  o;
      logic [7:0]  a;
      logic [15:0] d;
      o = 3'($urandom % 8);
      if ($urandom % 2) a = 8'(int'($urandom % 81) - 40);
      else              a = 8'($urandom);
      d = 16'($urandom);
      if ($urandom % 2) d = 16'($signed(d) >>> ($urandom % 16));
      apply(($urandom % 8) != 0, o, a, 1'($urandom), ($urandom % 4) == 0, d, tags[o]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule